// File: doc/BRIEF.md
# Paged Non-Volatile Data Array Write Controller

This block sits between a CPU data bus and a 64-byte non-volatile data page, modelled here as a register array. The CPU reads array bytes directly with the same single-cycle registered latency as ordinary data memory. Writes start a programming cycle, and a busy flag covers that cycle for a parameterised number of clocks. The page is reachable only while its bank-select input is high and the power-off bit of the control register is clear.

Programming runs in one of two modes. In byte mode every accepted write programs one location. In row-parallel mode, writes are gathered into an 8-byte row buffer that has a valid flag per byte. The first gathered write fixes the row, and row n spans addresses 8n to 8n+7, so the row is addr[5:3] and the byte is addr[2:0]. Setting the start bit then commits only the valid bytes in one busy period. While busy, the control register is frozen and only the busy flag reads back. Array reads return 00h and array writes are dropped.

Top module: `nvp_page_ctrl`

## Requirements
- R1: After reset, ctl_rdata reads 00h, busy and done are low, and rdata is 00h.
- R2: An array access counts only when bank_sel is high and the power-off bit is clear. Otherwise a read returns 00h and a write is dropped.
- R3: An accepted read returns the stored byte on rdata in the cycle after the request. Without an accepted read the next rdata is 00h.
- R4: In byte mode (ctl bit 2 = 0), an accepted write programs its location only when program-enable (ctl bit 1) is set. With program-enable clear, the write starts no cycle and changes nothing.
- R5: A programming cycle holds busy high for exactly PROG_CYCLES clocks. done is high for one cycle, the first cycle with busy low again.
- R6: While busy, array reads return 00h and array writes are dropped.
- R7: While busy, control writes are ignored and ctl_rdata reads exactly 40h, which is only the busy bit.
- R8: The control layout is: bit 0 power-off, bit 1 program-enable, bit 2 parallel mode, bit 3 start, bit 6 busy (read-only). Bits 4, 5 and 7 always read 0.
- R9: In parallel mode (ctl bit 2 = 1) with program-enable set, writes are only latched. A control write with start, parallel and program-enable set, power-off clear, bank_sel high and at least one valid byte then programs exactly the valid bytes in one busy period. The other bytes of the row keep their values.
- R10: The first latched write fixes the row as addr[5:3]. A later write to another row is dropped until the commit.
- R11: start reads 0 again once busy ends. The commit clears the valid flags, so a later start with no latched bytes starts no cycle.
- R12: A control write in the same cycle as an array write drops the array write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 1 | Page bank selected |
| arr_rd | input | 1 | Array read request |
| arr_wr | input | 1 | Array write request |
| arr_addr | input | 6 | Array byte address |
| ctl_wr | input | 1 | Control register write |
| wdata | input | 8 | Write data for the array or the control register |
| rdata | output | 8 | Array read data, one cycle after the request |
| ctl_rdata | output | 8 | Control register view |
| busy | output | 1 | Programming cycle running |
| done | output | 1 | One-cycle pulse at the end of programming |

## Verification
A corrupted busy counter shows up at the ports as a wrong busy length, and the reference model flags it on the first clock where busy or done differ. A stale row number or stale valid flag in the row buffer stays hidden until the commit and the reads that follow it. At that point a byte appears at the wrong address, or a byte that should be untouched changes, and each directed readback names the address. A wrong mode or program-enable bit shows one cycle later, either on ctl_rdata or as a busy that never rises.

// File: rtl/nvp_pkg.sv
package nvp_pkg;
  localparam int CTL_OFF  = 0;
  localparam int CTL_PEN  = 1;
  localparam int CTL_PAR  = 2;
  localparam int CTL_GO   = 3;
  localparam int CTL_BUSY = 6;
  localparam int CTL_W    = 8;
endpackage

// File: rtl/nvp_col_bank.sv
module nvp_col_bank #(
  parameter int ROW_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ROW_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata_q
);
  localparam int DEPTH = 1 << ROW_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_q <= mem[raddr];
  end
endmodule

// File: rtl/nvp_row_latch.sv
module nvp_row_latch #(
  parameter int COL_W  = 3,
  parameter int ROW_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                lat_en,
  input  logic                                clear,
  input  logic [ROW_W-1:0]                    row_in,
  input  logic [COL_W-1:0]                    col_in,
  input  logic [DATA_W-1:0]                   wdata,
  output logic [(1<<COL_W)-1:0]               valid,
  output logic [ROW_W-1:0]                    row_q,
  output logic [(1<<COL_W)-1:0][DATA_W-1:0]   data_q,
  output logic                                any_valid
);
  localparam int NB = 1 << COL_W;

  logic accept;

  assign any_valid = |valid;
  assign accept    = lat_en && (!any_valid || row_in == row_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= '0;
      row_q  <= '0;
      data_q <= '0;
    end else if (clear) begin
      valid <= '0;
    end else if (accept) begin
      row_q          <= row_in;
      valid[col_in]  <= 1'b1;
      data_q[col_in] <= wdata;
    end
  end

  logic unused_nb;
  assign unused_nb = (NB == 0);
endmodule

// File: rtl/nvp_ctl_reg.sv
module nvp_ctl_reg
  import nvp_pkg::*;
#(
  parameter int PROG_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [3:0]        wbits,
  input  logic              byte_fire,
  input  logic              commit_ok,
  output logic              off,
  output logic              pen,
  output logic              par,
  output logic              busy,
  output logic              done,
  output logic              commit,
  output logic [CTL_W-1:0]  ctl_rdata
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic             go;
  logic [CNT_W-1:0] cnt;

  assign commit = ctl_wr && !busy && wbits[CTL_GO] && wbits[CTL_PAR] &&
                  wbits[CTL_PEN] && !wbits[CTL_OFF] && commit_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      off  <= 1'b0;
      pen  <= 1'b0;
      par  <= 1'b0;
      go   <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          go   <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else begin
        if (ctl_wr) begin
          off <= wbits[CTL_OFF];
          pen <= wbits[CTL_PEN];
          par <= wbits[CTL_PAR];
          go  <= commit;
        end
        if (commit || byte_fire) begin
          busy <= 1'b1;
          cnt  <= CNT_W'(PROG_CYCLES - 1);
        end
      end
    end
  end

  always_comb begin
    ctl_rdata = '0;
    if (busy) begin
      ctl_rdata[CTL_BUSY] = 1'b1;
    end else begin
      ctl_rdata[CTL_OFF] = off;
      ctl_rdata[CTL_PEN] = pen;
      ctl_rdata[CTL_PAR] = par;
      ctl_rdata[CTL_GO]  = go;
    end
  end
endmodule

// File: rtl/nvp_page_ctrl.sv
module nvp_page_ctrl
  import nvp_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int COL_W       = 3,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bank_sel,
  input  logic              arr_rd,
  input  logic              arr_wr,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  output logic              busy,
  output logic              done
);
  localparam int ROW_W = ADDR_W - COL_W;
  localparam int NB    = 1 << COL_W;

  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] rowa;
  logic             off, pen, par, commit;
  logic             acc, byte_fire, lat_en, rd_ok;
  logic             rd_ok_q;
  logic [COL_W-1:0] col_q;

  logic [NB-1:0]              lat_valid;
  logic [ROW_W-1:0]           lat_row;
  logic [NB-1:0][DATA_W-1:0]  lat_data;
  logic                       lat_any;
  logic [DATA_W-1:0]          bank_q [NB];

  assign col       = arr_addr[COL_W-1:0];
  assign rowa      = arr_addr[ADDR_W-1:COL_W];
  assign acc       = bank_sel && !off && !busy;
  assign byte_fire = arr_wr && !ctl_wr && acc && pen && !par;
  assign lat_en    = arr_wr && !ctl_wr && acc && pen && par;
  assign rd_ok     = arr_rd && acc;

  nvp_ctl_reg #(.PROG_CYCLES(PROG_CYCLES)) ctl_i (
    .clk       (clk),
    .rst       (rst),
    .ctl_wr    (ctl_wr),
    .wbits     (wdata[3:0]),
    .byte_fire (byte_fire),
    .commit_ok (bank_sel && lat_any),
    .off       (off),
    .pen       (pen),
    .par       (par),
    .busy      (busy),
    .done      (done),
    .commit    (commit),
    .ctl_rdata (ctl_rdata)
  );

  nvp_row_latch #(.COL_W(COL_W), .ROW_W(ROW_W), .DATA_W(DATA_W)) lat_i (
    .clk       (clk),
    .rst       (rst),
    .lat_en    (lat_en),
    .clear     (commit),
    .row_in    (rowa),
    .col_in    (col),
    .wdata     (wdata),
    .valid     (lat_valid),
    .row_q     (lat_row),
    .data_q    (lat_data),
    .any_valid (lat_any)
  );

  for (genvar c = 0; c < NB; c++) begin : g_col
    logic              we;
    logic [ROW_W-1:0]  wa;
    logic [DATA_W-1:0] wd;

    assign we = (byte_fire && col == COL_W'(c)) || (commit && lat_valid[c]);
    assign wa = byte_fire ? rowa  : lat_row;
    assign wd = byte_fire ? wdata : lat_data[c];

    nvp_col_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W)) bank_i (
      .clk     (clk),
      .we      (we),
      .waddr   (wa),
      .wdata   (wd),
      .raddr   (rowa),
      .rdata_q (bank_q[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ok_q <= 1'b0;
      col_q   <= '0;
    end else begin
      rd_ok_q <= rd_ok;
      col_q   <= col;
    end
  end

  assign rdata = rd_ok_q ? bank_q[col_q] : '0;
endmodule

// File: rtl/nvp_checker.sv
module nvp_checker #(
  parameter int PROG_CYCLES = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic [7:0] ctl_rdata,
  input logic [7:0] rdata
);
  int unsigned busy_len;

  always_ff @(posedge clk) begin
    if (rst) busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else busy_len <= 0;
  end

  // R5: busy window length, measured with a counter
  a_r5_busy_len: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> busy_len == PROG_CYCLES);

  // R5: done follows the end of busy
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R7: only the busy bit is visible while programming
  a_r7_busy_view: assert property (@(posedge clk) disable iff (rst)
    busy |-> ctl_rdata == 8'h40);

  // R8: reserved bits read zero
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    ctl_rdata[5:4] == 2'b00 && !ctl_rdata[7]);

  // R6: reads during busy return zero
  a_r6_read_blocked: assert property (@(posedge clk) disable iff (rst)
    busy |=> rdata == 8'h00);

  // R11: start reads clear once busy ends
  a_r11_start_clears: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !ctl_rdata[3]);
endmodule

bind nvp_page_ctrl nvp_checker #(.PROG_CYCLES(PROG_CYCLES)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .ctl_rdata (ctl_rdata),
  .rdata     (rdata)
);

// File: tb/nvp_page_ctrl_tb_top.sv
module nvp_page_ctrl_tb_top;
  localparam int PC = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bank_sel = 1'b1;
  logic       arr_rd = 1'b0;
  logic       arr_wr = 1'b0;
  logic [5:0] arr_addr = '0;
  logic       ctl_wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, ctl_rdata;
  logic       busy, done;

  int vecs = 0;
  int errs = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  nvp_page_ctrl #(.PROG_CYCLES(PC)) dut_i (
    .clk(clk), .rst(rst), .bank_sel(bank_sel), .arr_rd(arr_rd),
    .arr_wr(arr_wr), .arr_addr(arr_addr), .ctl_wr(ctl_wr), .wdata(wdata),
    .rdata(rdata), .ctl_rdata(ctl_rdata), .busy(busy), .done(done)
  );

  // behavioural reference model
  int m_mem [64];
  bit m_off, m_pen, m_par, m_go, m_busy, m_done;
  int m_cnt, m_row, m_rdq;
  bit m_valid [8];
  int m_buf [8];

  initial for (int i = 0; i < 64; i++) m_mem[i] = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_off = 0; m_pen = 0; m_par = 0; m_go = 0; m_busy = 0; m_done = 0;
      m_cnt = 0; m_row = 0; m_rdq = 0;
      for (int i = 0; i < 8; i++) m_valid[i] = 0;
    end else begin
      bit acc, bytew, lat, anyv, commit, nd;
      int rv;
      nd = 0;
      acc = bank_sel && !m_off && !m_busy;
      rv = (arr_rd && acc) ? m_mem[arr_addr] : 0;
      bytew = arr_wr && !ctl_wr && acc && m_pen && !m_par;
      lat = arr_wr && !ctl_wr && acc && m_pen && m_par;
      anyv = 0;
      for (int i = 0; i < 8; i++) anyv |= m_valid[i];
      commit = ctl_wr && !m_busy && wdata[3] && wdata[2] && wdata[1] &&
               !wdata[0] && bank_sel && anyv;
      if (m_busy) begin
        if (m_cnt == 0) begin m_busy = 0; m_go = 0; nd = 1; end
        else m_cnt--;
      end else begin
        if (ctl_wr) begin
          m_off = wdata[0]; m_pen = wdata[1]; m_par = wdata[2]; m_go = commit;
        end
        if (commit || bytew) begin m_busy = 1; m_cnt = PC - 1; end
      end
      if (bytew) m_mem[arr_addr] = wdata;
      if (commit) begin
        for (int i = 0; i < 8; i++) begin
          if (m_valid[i]) m_mem[m_row*8 + i] = m_buf[i];
          m_valid[i] = 0;
        end
      end else if (lat && (!anyv || int'(arr_addr >> 3) == m_row)) begin
        m_row = arr_addr >> 3;
        m_valid[arr_addr & 7] = 1;
        m_buf[arr_addr & 7] = wdata;
      end
      m_done = nd;
      m_rdq = rv;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      int ec;
      ec = m_busy ? 8'h40 : {m_go, m_par, m_pen, m_off};
      vecs++;
      if (int'(rdata) != m_rdq) begin
        errs++; $display("FAIL R3 rdata act=%h exp=%h", rdata, m_rdq);
      end
      if (int'(ctl_rdata) != ec) begin
        errs++; $display("FAIL R8 ctl_rdata act=%h exp=%h", ctl_rdata, ec);
      end
      if (busy != m_busy) begin
        errs++; $display("FAIL R5 busy act=%0b exp=%0b", busy, m_busy);
      end
      if (done != m_done) begin
        errs++; $display("FAIL R5 done act=%0b exp=%0b", done, m_done);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic ctlw(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1; wdata = v;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic aw(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); arr_wr = 1; arr_addr = a; wdata = d;
    @(negedge clk); arr_wr = 0;
  endtask

  task automatic ar(input logic [5:0] a, output int v);
    @(negedge clk); arr_rd = 1; arr_addr = a;
    @(negedge clk); arr_rd = 0; v = rdata;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      errs++;
      $display("FAIL watchdog act=%0d exp=<20000", cycles);
      finish_run();
    end
  end

  initial begin
    int v, n;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 ctl", ctl_rdata, 8'h00);
    chk("R1 busy", busy, 0);
    chk("R1 rdata", rdata, 0);

    // R8 masking of reserved and busy bits
    ctlw(8'hF2);
    chk("R8 mask", ctl_rdata, 8'h02);

    // R4 byte program, then R6/R7 lockout
    aw(6'h05, 8'hA5);
    chk("R4 busy set", busy, 1);
    ctlw(8'h00);
    chk("R7 busy view", ctl_rdata, 8'h40);
    aw(6'h06, 8'h77);
    ar(6'h05, v); chk("R6 read blocked", v, 0);
    wait_idle();
    chk("R7 ctl kept", ctl_rdata, 8'h02);
    ar(6'h05, v); chk("R4 programmed", v, 8'hA5);
    ar(6'h06, v); chk("R6 write dropped", v, 0);

    // R4 program-enable clear
    ctlw(8'h00);
    aw(6'h07, 8'h55);
    chk("R4 no busy", busy, 0);
    ar(6'h07, v); chk("R4 no write", v, 0);

    // R2 gating by power-off and bank_sel
    ctlw(8'h03);
    aw(6'h08, 8'h11);
    ar(6'h05, v); chk("R2 off read", v, 0);
    ctlw(8'h02);
    bank_sel = 0;
    aw(6'h09, 8'h22);
    ar(6'h05, v); chk("R2 bank read", v, 0);
    bank_sel = 1;
    ar(6'h08, v); chk("R2 off write", v, 0);
    ar(6'h09, v); chk("R2 bank write", v, 0);

    // R12 simultaneous control and array write
    @(negedge clk); ctl_wr = 1; arr_wr = 1; arr_addr = 6'h0A; wdata = 8'h02;
    @(negedge clk); ctl_wr = 0; arr_wr = 0;
    chk("R12 no busy", busy, 0);
    ar(6'h0A, v); chk("R12 dropped", v, 0);

    // R5 busy length and done pulse
    aw(6'h10, 8'h3C);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R5 busy len", n, PC);
    chk("R5 done", done, 1);
    @(negedge clk);
    chk("R5 done single", done, 0);
    ar(6'h10, v); chk("R3 readback", v, 8'h3C);

    // R9/R10 parallel row
    aw(6'h1B, 8'h44);
    wait_idle();
    ctlw(8'h06);
    aw(6'h1A, 8'h91);
    aw(6'h1C, 8'h92);
    aw(6'h1F, 8'h93);
    aw(6'h21, 8'h99);
    chk("R9 latch only", busy, 0);
    ar(6'h1A, v); chk("R9 not yet", v, 0);
    ctlw(8'h0E);
    chk("R9 commit busy", busy, 1);
    wait_idle();
    chk("R11 start clear", ctl_rdata, 8'h06);
    ar(6'h1A, v); chk("R9 byte a", v, 8'h91);
    ar(6'h1C, v); chk("R9 byte c", v, 8'h92);
    ar(6'h1F, v); chk("R9 byte f", v, 8'h93);
    ar(6'h1B, v); chk("R9 untouched", v, 8'h44);
    ar(6'h18, v); chk("R9 empty", v, 0);
    ar(6'h21, v); chk("R10 other row", v, 0);

    // R11 empty commit
    ctlw(8'h0E);
    chk("R11 no cycle", busy, 0);
    chk("R11 ctl", ctl_rdata, 8'h06);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule